// File: doc/BRIEF.md
# Byte-Wide EEPROM Access Controller with Burst Loader

This block sits between a host register port and an external byte-wide EEPROM. It reaches the EEPROM through a simple request/acknowledge byte interface. The host programs an EEPROM address register, a data register and a memory base register through four register selects. It then sets a bit in the control register to start one of three operations: a single-byte read, a single-byte write, or a burst load. Each request bit reads back as set while its operation runs, and the hardware clears it when the operation ends. A separate busy bit is set whenever any operation is in flight.

A burst load walks the EEPROM byte by byte, starting from the byte after the last EEPROM access. If no access has happened since reset, it starts from address zero. The byte stream is read as records of three bytes: a 16-bit target address sent high byte first, followed by one data byte. For each record the block emits a write on its internal memory port. The target memory address takes its upper bits from the base register and its lower 15 bits from the record address, and the top bit of the record address is dropped. A record address of 0xFFFF ends the burst, and no data byte is fetched for it.

Top module: `eeprom_burst_loader`

## Requirements
- R1: After reset every register reads zero, the control register reads 0x0, no EEPROM request is raised and no memory write is issued.
- R2: Writing control bit 1 (read) starts one EEPROM read at the address in the address register (select 1). When the operation ends, the returned byte is held in the data register (select 2).
- R3: Writing control bit 0 (write) starts one EEPROM write: the byte in the data register goes to the location in the address register, with the EEPROM write-enable raised.
- R4: The control register (select 0) reads bit 0 = write running, bit 1 = read running, bit 2 = burst running, bit 3 = busy. The request bits clear themselves when their operation ends.
- R5: Writing control bit 2 starts a burst. The first burst after reset, with no earlier access, starts reading at EEPROM address 0.
- R6: Any later burst starts at the EEPROM address one above the last byte accessed, whether that byte came from a single access or from a burst.
- R7: A burst reads records of address high byte, address low byte and data byte. A record whose address is 0xFFFF ends the burst after its two address bytes, and no further byte is read.
- R8: Each data byte of a burst produces a single-cycle memory write, one cycle after that byte is acknowledged. The memory address is {base register (select 3, 9 bits), record address bits [14:0]}; record address bit 15 is ignored.
- R9: While busy, host writes to any register, including new requests, have no effect.
- R10: If several request bits are written at once, only one operation starts, chosen in the order read, then write, then burst.
- R11: An EEPROM request keeps its address, write-enable and write data unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWe | input | 1 | Host register write strobe |
| hostSel | input | 2 | Register select: 0 control, 1 address, 2 data, 3 base |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Read data for the selected register, combinational |
| eeReq | output | 1 | EEPROM byte request, held until acknowledged |
| eeWe | output | 1 | High for a write request, low for a read request |
| eeAddr | output | 16 | EEPROM byte address |
| eeWrData | output | 8 | Byte to write |
| eeAck | input | 1 | EEPROM acknowledge, one pulse per completed byte |
| eeRdData | input | 8 | EEPROM read byte, valid with eeAck |
| memWe | output | 1 | Internal memory write strobe |
| memAddr | output | 24 | Internal memory write address |
| memData | output | 8 | Internal memory write data |

## Verification
Single reads are swept over four acknowledge latencies, from back-to-back acknowledges to three-cycle waits, and over a spread of addresses. This separates a data capture on the wrong acknowledge from a wrong address. Burst images mix a plain record, a record with bit 15 set and a record at the 15-bit limit, ending with the 0xFFFF marker. This shows whether bit 15 is masked, whether the base lands in the upper bits, and whether any byte is read past the end marker. Bursts run after reset, after another burst and after a single read, which distinguishes the three possible start addresses. Requests are also written while busy and in combinations, which exposes a missing busy gate and a wrong priority order.

// File: rtl/eeldr_pkg.sv
`timescale 1ns/1ps
package eeldr_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_READ  = 3'd1,
    S_WRITE = 3'd2,
    S_BHI   = 3'd3,
    S_BLO   = 3'd4,
    S_BDAT  = 3'd5
  } ldState_t;

  typedef struct packed {
    logic loadData;
    logic setPtr;
    logic incPtr;
    logic capHi;
    logic capLo;
    logic memWr;
  } dpStrobe_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_BASE = 2'd3;

  localparam int BIT_WR    = 0;
  localparam int BIT_RD    = 1;
  localparam int BIT_BURST = 2;
  localparam int BIT_BUSY  = 3;
endpackage

// File: rtl/eeldr_ctrl.sv
`timescale 1ns/1ps
module eeldr_ctrl
  import eeldr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] reqBits,
  input  logic       eeAck,
  input  logic       endMark,
  output ldState_t   state,
  output logic       busy,
  output dpStrobe_t  strobe
);
  ldState_t nextState;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (reqBits[BIT_RD])         nextState = S_READ;
        else if (reqBits[BIT_WR])    nextState = S_WRITE;
        else if (reqBits[BIT_BURST]) nextState = S_BHI;
      end
      S_READ: if (eeAck) begin
        strobe.loadData = 1'b1;
        strobe.setPtr   = 1'b1;
        nextState       = S_IDLE;
      end
      S_WRITE: if (eeAck) begin
        strobe.setPtr = 1'b1;
        nextState     = S_IDLE;
      end
      S_BHI: if (eeAck) begin
        strobe.capHi  = 1'b1;
        strobe.incPtr = 1'b1;
        nextState     = S_BLO;
      end
      S_BLO: if (eeAck) begin
        strobe.capLo  = 1'b1;
        strobe.incPtr = 1'b1;
        nextState     = endMark ? S_IDLE : S_BDAT;
      end
      S_BDAT: if (eeAck) begin
        strobe.memWr  = 1'b1;
        strobe.incPtr = 1'b1;
        nextState     = S_BHI;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != S_IDLE);

  // R4: an operation only finishes on an acknowledged byte
  a_r4_done_on_ack: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(eeAck));

  // R7: the memory strobe is only raised for a data byte of a record
  a_r7_memwr_in_burst: assert property (@(posedge clk) disable iff (!rstN)
    strobe.memWr |-> (busy && !strobe.setPtr && !strobe.loadData));
endmodule

// File: rtl/eeldr_dp.sv
`timescale 1ns/1ps
module eeldr_dp
  import eeldr_pkg::*;
#(
  parameter int EE_AW   = 16,
  parameter int BASE_W  = 9,
  parameter int HOST_DW = 16,
  parameter int REC_W   = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 hostWe,
  input  logic [1:0]           hostSel,
  input  logic [HOST_DW-1:0]   hostWrData,
  output logic [HOST_DW-1:0]   hostRdData,
  input  logic                 busy,
  input  ldState_t             state,
  input  dpStrobe_t            strobe,
  output logic [2:0]           reqBits,
  output logic                 endMark,
  input  logic [7:0]           eeRdData,
  output logic [EE_AW-1:0]     eeAddr,
  output logic [7:0]           eeWrData,
  output logic                 eeWe,
  output logic                 memWe,
  output logic [BASE_W+REC_W-2:0] memAddr,
  output logic [7:0]           memData
);
  localparam int LOW_W  = REC_W - 1;
  localparam int MEM_AW = BASE_W + LOW_W;

  logic [EE_AW-1:0]  addrReg, ptrReg;
  logic [7:0]        dataReg, recHi, recLo;
  logic [BASE_W-1:0] baseReg;
  logic              hostAcc;
  logic [LOW_W-1:0]  recLow;

  assign hostAcc = hostWe && !busy;
  assign reqBits = (hostAcc && hostSel == SEL_CTRL) ? hostWrData[2:0] : 3'b000;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      baseReg <= '0;
    end else begin
      if (hostAcc && hostSel == SEL_ADDR) addrReg <= hostWrData[EE_AW-1:0];
      if (hostAcc && hostSel == SEL_BASE) baseReg <= hostWrData[BASE_W-1:0];
      if (hostAcc && hostSel == SEL_DATA) dataReg <= hostWrData[7:0];
      else if (strobe.loadData)           dataReg <= eeRdData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrReg <= '0;
      recHi  <= '0;
      recLo  <= '0;
    end else begin
      if (strobe.setPtr)      ptrReg <= addrReg + 1'b1;
      else if (strobe.incPtr) ptrReg <= ptrReg + 1'b1;
      if (strobe.capHi) recHi <= eeRdData;
      if (strobe.capLo) recLo <= eeRdData;
    end
  end

  assign recLow = {recHi[LOW_W-9:0], recLo};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWe   <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWe <= strobe.memWr;
      if (strobe.memWr) begin
        memAddr <= {baseReg, recLow};
        memData <= eeRdData;
      end
    end
  end

  assign endMark  = (recHi == 8'hFF) && (eeRdData == 8'hFF);
  assign eeWe     = (state == S_WRITE);
  assign eeWrData = dataReg;
  assign eeAddr   = (state == S_READ || state == S_WRITE) ? addrReg : ptrReg;

  always_comb begin
    hostRdData = '0;
    unique case (hostSel)
      SEL_CTRL: begin
        hostRdData[BIT_WR]    = (state == S_WRITE);
        hostRdData[BIT_RD]    = (state == S_READ);
        hostRdData[BIT_BURST] = (state == S_BHI) || (state == S_BLO) || (state == S_BDAT);
        hostRdData[BIT_BUSY]  = busy;
      end
      SEL_ADDR: hostRdData[EE_AW-1:0]  = addrReg;
      SEL_DATA: hostRdData[7:0]        = dataReg;
      default:  hostRdData[BASE_W-1:0] = baseReg;
    endcase
  end

  // R9: no host write changes a register while an operation runs
  a_r9_base_frozen: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(baseReg) && $stable(addrReg));

  // R8: memory writes carry the base register in their upper bits
  a_r8_mem_high: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[MEM_AW-1:LOW_W] == baseReg));
endmodule

// File: rtl/eeprom_burst_loader.sv
`timescale 1ns/1ps
module eeprom_burst_loader
  import eeldr_pkg::*;
#(
  parameter int EE_AW   = 16,
  parameter int BASE_W  = 9,
  parameter int HOST_DW = 16,
  parameter int REC_W   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       hostWe,
  input  logic [1:0]                 hostSel,
  input  logic [HOST_DW-1:0]         hostWrData,
  output logic [HOST_DW-1:0]         hostRdData,
  output logic                       eeReq,
  output logic                       eeWe,
  output logic [EE_AW-1:0]           eeAddr,
  output logic [7:0]                 eeWrData,
  input  logic                       eeAck,
  input  logic [7:0]                 eeRdData,
  output logic                       memWe,
  output logic [BASE_W+REC_W-2:0]    memAddr,
  output logic [7:0]                 memData
);
  ldState_t  state;
  dpStrobe_t strobe;
  logic      busy, endMark;
  logic [2:0] reqBits;

  eeldr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqBits(reqBits), .eeAck(eeAck),
    .endMark(endMark), .state(state), .busy(busy), .strobe(strobe)
  );

  eeldr_dp #(.EE_AW(EE_AW), .BASE_W(BASE_W), .HOST_DW(HOST_DW), .REC_W(REC_W)) u_dp (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .busy(busy),
    .state(state), .strobe(strobe), .reqBits(reqBits), .endMark(endMark),
    .eeRdData(eeRdData), .eeAddr(eeAddr), .eeWrData(eeWrData), .eeWe(eeWe),
    .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  assign eeReq = busy;

  // R11: a pending request holds its address, direction and data
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (eeReq && !eeAck) |=> (eeReq && $stable(eeAddr) && $stable(eeWe) && $stable(eeWrData)));

  // R8: a memory write follows an acknowledged EEPROM byte
  a_r8_memwe_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($past(eeAck) && $past(eeReq) && !$past(eeWe)));
endmodule

// File: tb/sim_eeprom_burst_loader.sv
`timescale 1ns/1ps
module sim_eeprom_burst_loader;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostSel = 2'd0;
  logic [15:0] hostWrData = 16'd0;
  logic [15:0] hostRdData;
  logic        eeReq, eeWe, eeAck, memWe;
  logic [15:0] eeAddr;
  logic [7:0]  eeWrData, eeRdData, memData;
  logic [23:0] memAddr;

  int nChk = 0, nErr = 0;
  int lat = 1, latCnt = 0;
  int accCount = 0, wrCount = 0, holdErr = 0, mwCount = 0;
  int accLog [0:127];
  int mwAddr [0:15];
  int mwData [0:15];
  logic [7:0]  eeMem [0:511];
  logic        prevWait = 1'b0;
  logic [15:0] prevAddr = 16'd0;

  always #4 clk = ~clk;

  eeprom_burst_loader u0 (
    .clk(clk), .rstN(rstN), .hostWe(hostWe), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .eeReq(eeReq),
    .eeWe(eeWe), .eeAddr(eeAddr), .eeWrData(eeWrData), .eeAck(eeAck),
    .eeRdData(eeRdData), .memWe(memWe), .memAddr(memAddr), .memData(memData)
  );

  assign eeRdData = eeMem[eeAddr[8:0]];

  initial eeAck = 1'b0;

  always @(posedge clk) begin
    if (rstN && eeReq) begin
      if (latCnt >= lat) begin eeAck <= 1'b1; latCnt <= 0; end
      else begin eeAck <= 1'b0; latCnt <= latCnt + 1; end
    end else begin
      eeAck <= 1'b0; latCnt <= 0;
    end
    if (rstN && eeReq && eeAck) begin
      accLog[accCount] <= int'(eeAddr);
      accCount <= accCount + 1;
      if (eeWe) begin
        eeMem[eeAddr[8:0]] <= eeWrData;
        wrCount <= wrCount + 1;
      end
    end
    if (rstN && prevWait && eeReq && eeAddr !== prevAddr) holdErr <= holdErr + 1;
    prevWait <= eeReq && !eeAck;
    prevAddr <= eeAddr;
    if (rstN && memWe) begin
      mwAddr[mwCount] <= int'(memAddr);
      mwData[mwCount] <= int'(memData);
      mwCount <= mwCount + 1;
    end
  end

  function automatic logic [7:0] fillByte(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    hostWe = 1'b1; hostSel = sel; hostWrData = val;
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic [1:0] sel, output logic [15:0] val);
    @(negedge clk);
    hostSel = sel;
    #1 val = hostRdData;
  endtask

  task automatic waitIdle();
    logic [15:0] v;
    for (int n = 0; n < 300; n++) begin
      hostRead(2'd0, v);
      if (v[3] == 1'b0) return;
    end
    chk(1'b0, "R4 busy never cleared", int'(v), 0);
  endtask

  int baseVal = 'h1A5;

  initial begin
    logic [15:0] v;
    int prev, a, prevMw;
    for (int i = 0; i < 512; i++) eeMem[i] = fillByte(i);
    // burst image at 0: three records then end marker
    eeMem[0] = 8'h00; eeMem[1] = 8'h05; eeMem[2]  = 8'hA1;
    eeMem[3] = 8'h81; eeMem[4] = 8'h23; eeMem[5]  = 8'hB2;
    eeMem[6] = 8'h7F; eeMem[7] = 8'hFF; eeMem[8]  = 8'hC3;
    eeMem[9] = 8'hFF; eeMem[10] = 8'hFF;
    // second image directly after
    eeMem[11] = 8'h00; eeMem[12] = 8'h42; eeMem[13] = 8'h5A;
    eeMem[14] = 8'hFF; eeMem[15] = 8'hFF;
    // image after the single read at 0x100
    eeMem[9'h101] = 8'hFF; eeMem[9'h102] = 8'hFF;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      hostRead(2'(s), v);
      chk(v == 16'h0, "R1 register reset value", int'(v), 0);
    end
    chk(eeReq == 1'b0 && memWe == 1'b0, "R1 idle outputs", int'({eeReq, memWe}), 0);

    hostWrite(2'd3, 16'(baseVal));
    hostRead(2'd3, v);
    chk(int'(v) == baseVal, "R9 base writable when idle", int'(v), baseVal);

    // first burst after reset, with ignored host writes during it
    hostWrite(2'd0, 16'h4);
    hostRead(2'd0, v);
    chk(v == 16'hC, "R4 burst running bits", int'(v), 'hC);
    hostWrite(2'd3, 16'h0);
    hostWrite(2'd0, 16'h2);
    hostWrite(2'd1, 16'h55);
    waitIdle();
    hostRead(2'd3, v);
    chk(int'(v) == baseVal, "R9 base unchanged while busy", int'(v), baseVal);
    hostRead(2'd1, v);
    chk(v == 16'h0, "R9 address unchanged while busy", int'(v), 0);
    chk(accCount == 11, "R7 bytes read by burst", accCount, 11);
    chk(accLog[0] == 0, "R5 first burst starts at 0", accLog[0], 0);
    chk(accLog[10] == 10, "R7 last byte is end marker", accLog[10], 10);
    chk(mwCount == 3, "R8 memory write count", mwCount, 3);
    chk(mwAddr[0] == ((baseVal << 15) | 'h0005) && mwData[0] == 'hA1,
        "R8 record 0", mwAddr[0], (baseVal << 15) | 'h0005);
    chk(mwAddr[1] == ((baseVal << 15) | 'h0123) && mwData[1] == 'hB2,
        "R8 bit 15 ignored", mwAddr[1], (baseVal << 15) | 'h0123);
    chk(mwAddr[2] == ((baseVal << 15) | 'h7FFF) && mwData[2] == 'hC3,
        "R8 record at 15-bit limit", mwAddr[2], (baseVal << 15) | 'h7FFF);

    // second burst resumes after the end marker
    hostWrite(2'd0, 16'h4);
    waitIdle();
    chk(accLog[11] == 11, "R6 burst resumes after burst", accLog[11], 11);
    chk(accCount == 16, "R7 second burst length", accCount, 16);
    chk(mwCount == 4 && mwAddr[3] == ((baseVal << 15) | 'h42) && mwData[3] == 'h5A,
        "R8 second burst record", mwAddr[3], (baseVal << 15) | 'h42);

    // single read sweep over latencies and addresses
    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int k = 0; k < 8; k++) begin
        a = 'h40 + k * 23 + l * 3;
        hostWrite(2'd1, 16'(a));
        hostWrite(2'd0, 16'h2);
        hostRead(2'd0, v);
        chk(v == 16'hA, "R4 read running bits", int'(v), 'hA);
        waitIdle();
        hostRead(2'd2, v);
        chk(v == 16'(fillByte(a)), "R2 read data", int'(v), int'(fillByte(a)));
        chk(accLog[accCount - 1] == a, "R2 read address", accLog[accCount - 1], a);
      end
    end
    chk(holdErr == 0, "R11 request held until ack", holdErr, 0);

    // single write
    lat = 2;
    hostWrite(2'd1, 16'h1F0);
    hostWrite(2'd2, 16'h3C);
    prev = wrCount;
    hostWrite(2'd0, 16'h1);
    hostRead(2'd0, v);
    chk(v == 16'h9, "R4 write running bits", int'(v), 'h9);
    waitIdle();
    chk(eeMem[9'h1F0] == 8'h3C && wrCount == prev + 1, "R3 byte written", int'(eeMem[9'h1F0]), 'h3C);
    hostWrite(2'd2, 16'h00);
    hostWrite(2'd0, 16'h2);
    waitIdle();
    hostRead(2'd2, v);
    chk(v == 16'h3C, "R3 written byte read back", int'(v), 'h3C);

    // burst after a single read resumes at the next address
    hostWrite(2'd1, 16'h100);
    hostWrite(2'd0, 16'h2);
    waitIdle();
    prev = accCount; prevMw = mwCount;
    hostWrite(2'd0, 16'h4);
    waitIdle();
    chk(accCount - prev == 2, "R7 end marker only burst", accCount - prev, 2);
    chk(accLog[prev] == 'h101, "R6 burst after single read", accLog[prev], 'h101);
    chk(mwCount == prevMw, "R7 no memory write for end marker", mwCount, prevMw);

    // priority of simultaneous requests
    lat = 1;
    hostWrite(2'd1, 16'h30);
    prev = accCount; prevMw = wrCount;
    hostWrite(2'd0, 16'h7);
    waitIdle();
    chk(accCount - prev == 1 && wrCount == prevMw, "R10 read wins", accCount - prev, 1);
    hostRead(2'd2, v);
    chk(v == 16'(fillByte('h30)), "R10 read data", int'(v), int'(fillByte('h30)));
    hostWrite(2'd1, 16'h31);
    hostWrite(2'd2, 16'h77);
    prev = accCount;
    hostWrite(2'd0, 16'h5);
    waitIdle();
    chk(accCount - prev == 1 && eeMem[9'h31] == 8'h77, "R10 write beats burst",
        accCount - prev, 1);
    chk(holdErr == 0, "R11 request held until ack", holdErr, 0);

    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    #800000;
    nChk++; nErr++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule